// File: doc/BRIEF.md
# DRAM Refresh Request and CAS-before-RAS Cycle Generator

This block keeps dynamic memory alive. It watches a slow reference clock, counts its rising edges in the bus clock domain and, once each programmed refresh interval has passed, raises a request to the memory bus arbiter. When the arbiter grants the bus, the block drives one CAS-before-RAS refresh cycle on the active-low row and column strobes. The length of that cycle is set by a two-bit code.

The interval is set by an 8-bit count N and lasts (N+1) x 4 reference ticks. A new count takes effect only when the current interval ends. If a second interval ends while a request is still waiting for grant, one extra refresh is held and issued after the first. Further expiries are dropped until the queue drains. Clearing the enable stops all requests, clears anything pending and restarts the interval timer.

Top module: `dram_refresh_timer`

## Requirements
- R1: A reference tick is one rising edge of `refClkIn` seen in the bus clock domain. With the block enabled, successive interval expiries (rising edges of `refReq` when every request is granted at once) lie exactly (N+1)*4 ticks apart, where N is `intervalCount`.
- R2: With N = 13 and a 3.6864 MHz reference, the interval is 56 ticks, about 15.19 us.
- R3: While `refreshEn` is 0, `refReq` stays 0. Clearing `refreshEn` discards any pending refresh, so re-enabling does not raise `refReq` at once.
- R4: `cycleCode` selects a cycle of L bus clocks: 0 gives 8, 1 gives 6, 2 gives 5 and 3 gives 4. During the cycle `casN` is low for L-1 clocks and `rasN` is low for L-2 clocks. In the last clock both are high.
- R5: Every refresh cycle is CAS-before-RAS. `casN` goes low in the first clock after the grant is taken and `rasN` in the second. `rasN` is never low while `casN` is high, and both rise together.
- R6: If an interval expires while a request is still ungranted, one extra refresh is held. After the first cycle ends, `refReq` rises again. After the second cycle it stays low, because at most one refresh is queued.
- R7: A change of `intervalCount` made mid-interval does not shorten or stretch that interval. The new count governs the interval that starts at the next expiry.
- R8: After reset, `refReq` is 0 and `rasN` and `casN` are 1.
- R9: `refReq` stays high until the arbiter grants. It is taken on a clock edge where both `refReq` and `refGnt` are 1, and it drops in the next clock. `refReq` is never high while a refresh cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low reset, synchronous to `clk` |
| refClkIn | input | 1 | Slow reference clock; each rising edge counts as one tick |
| refreshEn | input | 1 | Enables interval counting and refresh requests |
| intervalCount | input | 8 | Interval count N; the interval is (N+1)*4 ticks |
| cycleCode | input | 2 | Refresh cycle length select (8/6/5/4 clocks) |
| refGnt | input | 1 | Bus grant from the arbiter |
| refReq | output | 1 | Refresh request to the arbiter |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low (all column strobes together) |

## Verification
On every clock, the assertions check the strobe ordering, the handshake and the enable gating: RAS never low without CAS, RAS never falling unless CAS was already low, the CAS low run bounded by the longest cycle, no request while disabled or mid-cycle, and CAS falling one clock after a taken grant. Only the bench scenarios can show the interval lengths in reference ticks (including the 15.19 us case and the deferred reload of a new count), the exact strobe counts for each cycle code, and the single-deep queue of pending refreshes. Each of these needs a measurement over many clocks, or a given order of expiries and grants.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;

  localparam int LEN_W = 4;

  // Strobes from control to datapath
  typedef struct packed {
    logic timerClear;   // hold prescaler and interval counter at zero
    logic cycStart;     // grant taken: zero cycle counter, latch length
    logic cycStep;      // advance cycle counter
  } refStrobe_t;

  // Status from datapath to control
  typedef struct packed {
    logic expire;       // interval ended this clock
    logic cycAtFirst;   // cycle counter at clock 0
    logic cycAtDrop;    // cycle counter at L-2: strobes rise next
    logic cycAtLast;    // cycle counter at L-1: cycle ends next
  } refStatus_t;

  function automatic logic [LEN_W-1:0] cycleLength(input logic [1:0] code);
    case (code)
      2'd0:    cycleLength = LEN_W'(8);
      2'd1:    cycleLength = LEN_W'(6);
      2'd2:    cycleLength = LEN_W'(5);
      default: cycleLength = LEN_W'(4);
    endcase
  endfunction

endpackage

// File: rtl/dram_refresh_datapath.sv
module dram_refresh_datapath
  import dram_refresh_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClkIn,
  input  logic [CNT_W-1:0] intervalCount,
  input  logic [1:0]       cycleCode,
  input  refStrobe_t       strobe,
  output refStatus_t       status
);

  logic [SYNC_STAGES:0] syncQ;
  logic                 tickPulse;
  logic [PRE_W-1:0]     preQ;
  logic                 quarterTick;
  logic [CNT_W-1:0]     intervalQ;
  logic [LEN_W-1:0]     cycCnt;
  logic [LEN_W-1:0]     lenQ;

  // Synchroniser plus one stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-1:0], refClkIn};
  end

  assign tickPulse = syncQ[SYNC_STAGES-1] & ~syncQ[SYNC_STAGES];

  // Divide-by-2**PRE_W prescaler
  always_ff @(posedge clk) begin
    if (!rstN || strobe.timerClear) preQ <= '0;
    else if (tickPulse)             preQ <= preQ + PRE_W'(1);
  end

  assign quarterTick = tickPulse && (preQ == {PRE_W{1'b1}});

  // Interval down-counter, reloaded only when it expires
  always_ff @(posedge clk) begin
    if (!rstN || strobe.timerClear) begin
      intervalQ <= '0;
    end else if (quarterTick) begin
      if (intervalQ == '0) intervalQ <= intervalCount;
      else                 intervalQ <= intervalQ - CNT_W'(1);
    end
  end

  // Refresh cycle counter and latched length
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cycCnt <= '0;
      lenQ   <= cycleLength(2'd3);
    end else if (strobe.cycStart) begin
      cycCnt <= '0;
      lenQ   <= cycleLength(cycleCode);
    end else if (strobe.cycStep) begin
      cycCnt <= cycCnt + LEN_W'(1);
    end
  end

  always_comb begin
    status.expire     = quarterTick && (intervalQ == '0);
    status.cycAtFirst = (cycCnt == '0);
    status.cycAtDrop  = (cycCnt == lenQ - LEN_W'(2));
    status.cycAtLast  = (cycCnt == lenQ - LEN_W'(1));
  end

endmodule

// File: rtl/dram_refresh_control.sv
module dram_refresh_control
  import dram_refresh_pkg::*;
#(
  parameter int QUEUE_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       refreshEn,
  input  logic       refGnt,
  input  refStatus_t status,
  output refStrobe_t strobe,
  output logic       refReq,
  output logic       rasN,
  output logic       casN
);

  localparam int PEND_W = $clog2(QUEUE_DEPTH + 1);
  localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(QUEUE_DEPTH);

  typedef enum logic {IDLE, ACTIVE} refState_e;

  refState_e         stateQ;
  logic [PEND_W-1:0] pendQ, pendNext;
  logic              grantTake;

  assign refReq    = refreshEn && (pendQ != '0) && (stateQ == IDLE);
  assign grantTake = refReq && refGnt;

  always_comb begin
    strobe.timerClear = !refreshEn;
    strobe.cycStart   = grantTake;
    strobe.cycStep    = (stateQ == ACTIVE);
  end

  always_comb begin
    pendNext = pendQ;
    if (status.expire && pendQ != PEND_MAX) pendNext = pendNext + PEND_W'(1);
    if (grantTake)                          pendNext = pendNext - PEND_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN)           pendQ <= '0;
    else if (!refreshEn) pendQ <= '0;
    else                 pendQ <= pendNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= IDLE;
      rasN   <= 1'b1;
      casN   <= 1'b1;
    end else begin
      case (stateQ)
        IDLE: begin
          if (grantTake) begin
            stateQ <= ACTIVE;
            casN   <= 1'b0;
          end
        end
        default: begin
          if (status.cycAtDrop) begin
            rasN <= 1'b1;
            casN <= 1'b1;
          end else if (status.cycAtFirst) begin
            rasN <= 1'b0;
          end
          if (status.cycAtLast) stateQ <= IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer
  import dram_refresh_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PRE_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int QUEUE_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             refClkIn,
  input  logic             refreshEn,
  input  logic [CNT_W-1:0] intervalCount,
  input  logic [1:0]       cycleCode,
  input  logic             refGnt,
  output logic             refReq,
  output logic             rasN,
  output logic             casN
);

  refStrobe_t strobe;
  refStatus_t status;

  dram_refresh_datapath #(
    .CNT_W(CNT_W), .PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)
  ) datapath_i (
    .clk(clk), .rstN(rstN), .refClkIn(refClkIn),
    .intervalCount(intervalCount), .cycleCode(cycleCode),
    .strobe(strobe), .status(status)
  );

  dram_refresh_control #(
    .QUEUE_DEPTH(QUEUE_DEPTH)
  ) control_i (
    .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .refGnt(refGnt),
    .status(status), .strobe(strobe),
    .refReq(refReq), .rasN(rasN), .casN(casN)
  );

endmodule

// File: rtl/dram_refresh_checker.sv
module dram_refresh_checker (
  input logic clk,
  input logic rstN,
  input logic refreshEn,
  input logic refGnt,
  input logic refReq,
  input logic rasN,
  input logic casN
);

  // Longest cycle is 8 clocks, so CAS may stay low for at most 7
  logic [3:0] casLowRun;
  always_ff @(posedge clk) begin
    if (!rstN)     casLowRun <= '0;
    else if (!casN) casLowRun <= (casLowRun == 4'hF) ? casLowRun : casLowRun + 4'd1;
    else            casLowRun <= '0;
  end

  assert_cas_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    casLowRun <= 4'd7);

  assert_ras_needs_cas_R5: assert property (@(posedge clk) disable iff (!rstN)
    !rasN |-> !casN);

  assert_cbr_order_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> ($past(casN) == 1'b0));

  assert_req_enabled_R3: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> refreshEn);

  assert_req_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> (rasN && casN));

  assert_grant_cas_R9: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && refGnt) |=> (!casN && rasN && !refReq));

endmodule

bind dram_refresh_timer dram_refresh_checker chk_i (
  .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .refGnt(refGnt),
  .refReq(refReq), .rasN(rasN), .casN(casN)
);

// File: tb/dram_refresh_timer_tb.sv
module dram_refresh_timer_tb_top;

  localparam int REF_HALF = 14;            // reference period 28 bus clocks
  localparam int REF_PER  = 2 * REF_HALF;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       refClk = 1'b0;
  logic       refreshEn = 1'b0;
  logic [7:0] intervalCount = 8'd0;
  logic [1:0] cycleCode = 2'd3;
  logic       refGnt = 1'b0;
  logic       refReq, rasN, casN;

  int  testCount = 0;
  int  failCount = 0;
  longint cycleNo = 0;
  int  refDiv = 0;
  bit  benchDone = 1'b0;

  dram_refresh_timer dut_i (
    .clk(clk), .rstN(rstN), .refClkIn(refClk), .refreshEn(refreshEn),
    .intervalCount(intervalCount), .cycleCode(cycleCode), .refGnt(refGnt),
    .refReq(refReq), .rasN(rasN), .casN(casN)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cycleNo <= cycleNo + 1;

  always @(negedge clk) begin
    if (refDiv == REF_HALF - 1) begin
      refDiv = 0;
      refClk = ~refClk;
    end else begin
      refDiv = refDiv + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testCount++;
    if (!ok) begin
      failCount++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic waitRise(output longint t);
    logic prev;
    prev = refReq;
    t = -1;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (!prev && refReq) begin
        t = cycleNo;
        return;
      end
      prev = refReq;
    end
  endtask

  task automatic giveGrant();
    @(negedge clk) refGnt = 1'b1;
    @(negedge clk) refGnt = 1'b0;
  endtask

  task automatic restart(input logic [7:0] n, input logic [1:0] code);
    @(negedge clk);
    refreshEn = 1'b0;
    intervalCount = n;
    cycleCode = code;
    @(negedge clk) refreshEn = 1'b1;
  endtask

  // R8
  task automatic testReset();
    check(refReq == 1'b0, "R8 refReq after reset", refReq, 0);
    check(rasN == 1'b1, "R8 rasN after reset", rasN, 1);
    check(casN == 1'b1, "R8 casN after reset", casN, 1);
  endtask

  // R1 / R2: gap between granted requests
  task automatic testPeriod(input logic [7:0] n, input string tag);
    longint t0, t1, expGap;
    restart(n, 2'd3);
    expGap = longint'((int'(n) + 1) * 4 * REF_PER);
    waitRise(t0);
    giveGrant();
    waitRise(t1);
    giveGrant();
    check(t0 >= 0 && t1 >= 0 && (t1 - t0) == expGap, tag, t1 - t0, expGap);
  endtask

  // R2: the 15.19 us case, time computed from ticks at 3.6864 MHz
  task automatic testCrystal();
    longint t0, t1, ticks;
    real us;
    restart(8'd13, 2'd3);
    waitRise(t0);
    giveGrant();
    waitRise(t1);
    giveGrant();
    ticks = (t1 - t0) / REF_PER;
    us = real'(ticks) / 3.6864;
    check(ticks == 56, "R2 interval ticks for N=13", ticks, 56);
    check(us > 15.18 && us < 15.20, "R2 interval ns x1000 near 15190", longint'(us * 1000.0), 15190);
  endtask

  // R3
  task automatic testDisable();
    int seen;
    restart(8'd0, 2'd3);
    @(negedge clk) refreshEn = 1'b0;
    seen = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (refReq) seen++;
    end
    check(seen == 0, "R3 no request while disabled", seen, 0);
    refreshEn = 1'b1;
    begin
      longint t;
      waitRise(t);
    end
    @(negedge clk) refreshEn = 1'b0;
    @(negedge clk) refreshEn = 1'b1;
    @(negedge clk);
    check(refReq == 1'b0, "R3 pending discarded on disable", refReq, 0);
  endtask

  // R4 / R5 / R9
  task automatic testCycle(input logic [1:0] code, input int len);
    longint t;
    int casLow, rasLow, firstCas, firstRas;
    restart(8'd0, code);
    waitRise(t);
    giveGrant();
    check(refReq == 1'b0, "R9 request drops after grant", refReq, 0);
    casLow = 0; rasLow = 0; firstCas = -1; firstRas = -1;
    for (int k = 0; k < 12; k++) begin
      if (!casN) begin casLow++; if (firstCas < 0) firstCas = k; end
      if (!rasN) begin rasLow++; if (firstRas < 0) firstRas = k; end
      @(negedge clk);
    end
    check(casLow == len - 1, "R4 casN low clocks", casLow, len - 1);
    check(rasLow == len - 2, "R4 rasN low clocks", rasLow, len - 2);
    check(firstCas == 0, "R5 casN first clock", firstCas, 0);
    check(firstRas == 1, "R5 rasN second clock", firstRas, 1);
  endtask

  // R6
  task automatic testPending();
    longint t;
    restart(8'd0, 2'd3);
    waitRise(t);
    repeat (250) @(negedge clk);
    check(refReq == 1'b1, "R9 request held until grant", refReq, 1);
    giveGrant();
    repeat (8) @(negedge clk);
    check(refReq == 1'b1, "R6 queued refresh re-requested", refReq, 1);
    giveGrant();
    repeat (8) @(negedge clk);
    check(refReq == 1'b0, "R6 only one refresh queued", refReq, 0);
  endtask

  // R7
  task automatic testReload();
    longint t0, t1, t2;
    restart(8'd13, 2'd3);
    waitRise(t0);
    giveGrant();
    repeat (20) @(negedge clk);
    intervalCount = 8'd0;
    waitRise(t1);
    giveGrant();
    waitRise(t2);
    giveGrant();
    check((t1 - t0) == 56 * REF_PER, "R7 running interval keeps old count", t1 - t0, 56 * REF_PER);
    check((t2 - t1) == 4 * REF_PER, "R7 new count after expiry", t2 - t1, 4 * REF_PER);
  endtask

  initial begin
    #1900000;
    if (!benchDone) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testPeriod(8'd0, "R1 interval N=0");
    testPeriod(8'd255, "R1 interval N=255");
    testCrystal();
    testDisable();
    testCycle(2'd0, 8);
    testCycle(2'd1, 6);
    testCycle(2'd2, 5);
    testCycle(2'd3, 4);
    testPending();
    testReload();
    benchDone = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule